// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the software-visible configuration and status store of an Ethernet MAC. A bus master reaches it through a single-access slave port with a strobe, a write enable, a word address and four byte selects. Each access is taken by a small two-state bus sequencer and answered with a one-cycle acknowledge. Twenty 32-bit word registers sit at byte offsets 0x00 to 0x4C. Each one has its own reset value and its own set of writable bits. A 256-word buffer-descriptor store sits at byte offsets 0x400 to 0x7FC. A hard reset does not clear it.

The bus sequencer has two states. `ST_IDLE` waits for the strobe. On the transition `ST_IDLE -> ST_RESP`, taken when the strobe is high, the access is accepted: a write lands in the register or the store, and read data is captured. `ST_RESP` drives the acknowledge for one cycle. Its transition `ST_RESP -> ST_IDLE` is unconditional. The register indices, in address order, are: mode (0), interrupt status (1), interrupt enable (2), the three inter-frame gap registers (3 to 5), frame length limits (6), retry settings (7), transmit descriptor count (8), pause control (9), management clock setup (10), management command (11), management address (12), management write data (13), management read data (14), management status (15), station address low and high (16, 17) and group hash low and high (18, 19).

Top module: `mac_regbank`

## Requirements
- R1: An access is accepted in any cycle where the bus sequencer is idle and `bus_stb` is high. `bus_ack` is high for exactly the following cycle, and the cycle after that never carries an acknowledge.
- R2: After `rst_n` is released, the registers read as follows: mode 0x0000A800, gap registers 3/4/5 0x12/0x0C/0x12, frame length 0x00400600, retry 0x000F003F, descriptor count 0x40, management clock 0x64. Every other register reads zero, apart from the two port-fed registers of R5. Any earlier write is lost.
- R3: Each register keeps only its writable bits, and all other bits read zero. The writable masks are: mode 0x1FFFF; interrupt enable and the three gap registers 0x7F; frame length, station low and both hash registers 0xFFFFFFFF; retry 0x000F003F; pause 0x7; management clock 0x3FF; management address 0x1F1F; management write data and station high 0xFFFF; descriptor count 0xFF.
- R4: A write changes byte n (bits 8n+7:8n) only where `bus_sel[n]` is 1. This applies to registers and to the descriptor store.
- R5: Management read data returns `mgmt_rdata` (16 bits). Management status returns `mgmt_stat` (3 bits). The management command register reads zero. Bus writes to these three registers have no effect.
- R6: Interrupt status holds 7 bits. A high bit on `irq_set` sets the matching bit. A write with `bus_sel[0]` high clears each bit that is written as 1. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: The descriptor count register takes a write only if the merged 32-bit value is at most 0x80. Otherwise it keeps its old value.
- R8: Word addresses 20 to 255 (byte offsets 0x50 to 0x3FC) are acknowledged and read zero. Writes to them change no register.
- R9: The descriptor store holds 256 words at byte offsets 0x400 to 0x7FC, and its contents survive `rst_n`.
- R10: Read-back is correct for any number of idle cycles between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset of the registers |
| bus_stb | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 9 | Word address (byte address bits 10:2) |
| bus_sel | input | 4 | Byte selects |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle access acknowledge |
| irq_set | input | 7 | Interrupt set pulses, one per status bit |
| mgmt_rdata | input | 16 | Value seen at management read data |
| mgmt_stat | input | 3 | Value seen at management status |

## Verification
The interrupt status register has two writers: the hardware set pulses on `irq_set` and the bus clear-by-writing-one. Both can act on the same clock edge. The bench raises a set pulse for one bit on exactly the edge where a clearing write to the status register is accepted. That write also names a second bit that has no set pulse. Reading the register back must show the pulsed bit still set and the other bit cleared.

// File: rtl/mac_regbank_pkg.sv
package mac_regbank_pkg;

    localparam int NREG = 20;

    localparam int R_MODE       = 0;
    localparam int R_IRQ_STAT   = 1;
    localparam int R_IRQ_EN     = 2;
    localparam int R_GAP_B2B    = 3;
    localparam int R_GAP_NB1    = 4;
    localparam int R_GAP_NB2    = 5;
    localparam int R_FRAME_LEN  = 6;
    localparam int R_RETRY      = 7;
    localparam int R_TXDESC_CNT = 8;
    localparam int R_PAUSE_CTL  = 9;
    localparam int R_MGMT_CFG   = 10;
    localparam int R_MGMT_CMD   = 11;
    localparam int R_MGMT_ADDR  = 12;
    localparam int R_MGMT_WDATA = 13;
    localparam int R_MGMT_RDATA = 14;
    localparam int R_MGMT_STAT  = 15;
    localparam int R_STN_LO     = 16;
    localparam int R_STN_HI     = 17;
    localparam int R_HASH_LO    = 18;
    localparam int R_HASH_HI    = 19;

    localparam logic [31:0] TXDESC_LIMIT = 32'h0000_0080;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;

    function automatic logic [31:0] reg_reset(int idx);
        case (idx)
            R_MODE:       return 32'h0000_A800;
            R_GAP_B2B:    return 32'h0000_0012;
            R_GAP_NB1:    return 32'h0000_000C;
            R_GAP_NB2:    return 32'h0000_0012;
            R_FRAME_LEN:  return 32'h0040_0600;
            R_RETRY:      return 32'h000F_003F;
            R_TXDESC_CNT: return 32'h0000_0040;
            R_MGMT_CFG:   return 32'h0000_0064;
            default:      return 32'h0000_0000;
        endcase
    endfunction

    // Bits a bus write may change; zero for read-only and empty registers.
    function automatic logic [31:0] wr_mask(int idx);
        case (idx)
            R_MODE:       return 32'h0001_FFFF;
            R_IRQ_EN,
            R_GAP_B2B,
            R_GAP_NB1,
            R_GAP_NB2:    return 32'h0000_007F;
            R_FRAME_LEN,
            R_STN_LO,
            R_HASH_LO,
            R_HASH_HI:    return 32'hFFFF_FFFF;
            R_RETRY:      return 32'h000F_003F;
            R_TXDESC_CNT: return 32'h0000_00FF;
            R_PAUSE_CTL:  return 32'h0000_0007;
            R_MGMT_CFG:   return 32'h0000_03FF;
            R_MGMT_ADDR:  return 32'h0000_1F1F;
            R_MGMT_WDATA,
            R_STN_HI:     return 32'h0000_FFFF;
            default:      return 32'h0000_0000;
        endcase
    endfunction

    // Bits that may read back as one.
    function automatic logic [31:0] rd_mask(int idx);
        case (idx)
            R_IRQ_STAT:   return 32'h0000_007F;
            R_MGMT_RDATA: return 32'h0000_FFFF;
            R_MGMT_STAT:  return 32'h0000_0007;
            default:      return wr_mask(idx);
        endcase
    endfunction

    function automatic logic [31:0] sel_bits(logic [3:0] sel);
        return {{8{sel[3]}}, {8{sel[2]}}, {8{sel[1]}}, {8{sel[0]}}};
    endfunction

endpackage

// File: rtl/mac_regbank_busctl.sv
module mac_regbank_busctl
    import mac_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic accept,
    output logic ack
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (stb) begin
                    accept  = 1'b1;
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                ack     = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/mac_regbank_regs.sv
module mac_regbank_regs
    import mac_regbank_pkg::*;
#(
    parameter int IRQW  = 7,
    parameter int MRDW  = 16,
    parameter int MSTW  = 3,
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [3:0]      wr_sel,
    input  logic [31:0]     wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [31:0]     rd_data,
    input  logic [IRQW-1:0] irq_set,
    input  logic [MRDW-1:0] mgmt_rdata,
    input  logic [MSTW-1:0] mgmt_stat
);

    logic [31:0] stor [NREG];
    logic [31:0] bmask;

    assign bmask = sel_bits(wr_sel);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [31:0] MSK = wr_mask(gi);
        localparam logic [31:0] RST = reg_reset(gi);

        if (gi == R_IRQ_STAT) begin : g_w1c
            logic            hit;
            logic [IRQW-1:0] q;
            logic [IRQW-1:0] clr;
            assign hit = wr_en && (wr_idx == IW'(gi));
            assign clr = hit ? (wr_data[IRQW-1:0] & bmask[IRQW-1:0]) : '0;
            // set pulses applied after the clear: set wins on a tie
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= (q & ~clr) | irq_set;
            end
            assign stor[gi] = {{(32-IRQW){1'b0}}, q};
        end else if (MSK == 32'h0) begin : g_none
            assign stor[gi] = 32'h0;
        end else begin : g_rw
            logic        hit;
            logic        ok;
            logic [31:0] q;
            logic [31:0] merged;
            assign hit    = wr_en && (wr_idx == IW'(gi));
            assign merged = (q & ~bmask) | (wr_data & bmask);
            if (gi == R_TXDESC_CNT) begin : g_lim
                assign ok = (merged <= TXDESC_LIMIT);
            end else begin : g_nolim
                assign ok = 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= RST;
                else if (hit && ok) q <= merged & MSK;
            end
            assign stor[gi] = q;
        end
    end

    always_comb begin
        rd_data = 32'h0;
        if (rd_idx == IW'(R_MGMT_RDATA))
            rd_data = {{(32-MRDW){1'b0}}, mgmt_rdata};
        else if (rd_idx == IW'(R_MGMT_STAT))
            rd_data = {{(32-MSTW){1'b0}}, mgmt_stat};
        else if (rd_idx < IW'(NREG))
            rd_data = stor[rd_idx];
    end

endmodule

// File: rtl/mac_regbank_dstore.sv
module mac_regbank_dstore #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [3:0]    sel,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    // No reset: contents are kept across a hard reset of the bank.
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int b = 0; b < 4; b++) begin
                    if (sel[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/mac_regbank.sv
module mac_regbank
    import mac_regbank_pkg::*;
#(
    parameter int ADR_W     = 11,
    parameter int RAM_DEPTH = 256,
    parameter int RAM_BASE  = 256,
    parameter int IRQW      = 7,
    parameter int MRDW      = 16,
    parameter int MSTW      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [ADR_W-1:2] bus_adr,
    input  logic [3:0]       bus_sel,
    input  logic [31:0]      bus_wdat,
    output logic [31:0]      bus_rdat,
    output logic             bus_ack,
    input  logic [IRQW-1:0]  irq_set,
    input  logic [MRDW-1:0]  mgmt_rdata,
    input  logic [MSTW-1:0]  mgmt_stat
);

    localparam int WORD_W = ADR_W - 2;
    localparam int IW     = $clog2(NREG);
    localparam int RAW    = $clog2(RAM_DEPTH);

    logic              accept;
    logic              is_reg;
    logic              is_ram;
    logic [31:0]       reg_rd;
    logic [31:0]       ram_rd;
    logic [31:0]       rdat_q;
    logic              src_ram_q;
    logic [WORD_W-1:0] word;

    assign word   = bus_adr;
    assign is_reg = (word < WORD_W'(NREG));
    assign is_ram = (word >= WORD_W'(RAM_BASE));

    mac_regbank_busctl u_busctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (bus_stb),
        .accept (accept),
        .ack    (bus_ack)
    );

    mac_regbank_regs #(
        .IRQW (IRQW),
        .MRDW (MRDW),
        .MSTW (MSTW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept && bus_we && is_reg),
        .wr_idx     (word[IW-1:0]),
        .wr_sel     (bus_sel),
        .wr_data    (bus_wdat),
        .rd_idx     (word[IW-1:0]),
        .rd_data    (reg_rd),
        .irq_set    (irq_set),
        .mgmt_rdata (mgmt_rdata),
        .mgmt_stat  (mgmt_stat)
    );

    mac_regbank_dstore #(
        .DEPTH (RAM_DEPTH)
    ) u_dstore (
        .clk   (clk),
        .en    (accept && is_ram),
        .we    (bus_we),
        .sel   (bus_sel),
        .addr  (word[RAW-1:0]),
        .wdata (bus_wdat),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat_q    <= 32'h0;
            src_ram_q <= 1'b0;
        end else if (accept) begin
            rdat_q    <= is_reg ? reg_rd : 32'h0;
            src_ram_q <= is_ram;
        end
    end

    assign bus_rdat = src_ram_q ? ram_rd : rdat_q;

endmodule

// File: rtl/mac_regbank_chk.sv
module mac_regbank_chk
    import mac_regbank_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_stb,
    input logic        bus_we,
    input logic [10:2] bus_adr,
    input logic        bus_ack,
    input logic [31:0] bus_rdat
);

    p_ack_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_ack) |=> bus_ack);

    p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_masked_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !bus_we && (bus_adr < 9'(NREG)))
            |-> ((bus_rdat & ~rd_mask(int'(bus_adr))) == 32'h0));

    p_desc_cnt_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !bus_we && (bus_adr == 9'(R_TXDESC_CNT)))
            |-> (bus_rdat <= TXDESC_LIMIT));

    p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !bus_we && (bus_adr >= 9'(NREG)) && (bus_adr < 9'd256))
            |-> (bus_rdat == 32'h0));

endmodule

bind mac_regbank mac_regbank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_stb  (bus_stb),
    .bus_we   (bus_we),
    .bus_adr  (bus_adr),
    .bus_ack  (bus_ack),
    .bus_rdat (bus_rdat)
);

// File: tb/mac_regbank_bench.sv
module mac_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:2] bus_adr = '0;
    logic [3:0]  bus_sel = 4'h0;
    logic [31:0] bus_wdat = '0;
    logic [31:0] bus_rdat;
    logic        bus_ack;
    logic [6:0]  irq_set = '0;
    logic [15:0] mgmt_rdata = '0;
    logic [2:0]  mgmt_stat = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    mac_regbank u_mac_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_stb    (bus_stb),
        .bus_we     (bus_we),
        .bus_adr    (bus_adr),
        .bus_sel    (bus_sel),
        .bus_wdat   (bus_wdat),
        .bus_rdat   (bus_rdat),
        .bus_ack    (bus_ack),
        .irq_set    (irq_set),
        .mgmt_rdata (mgmt_rdata),
        .mgmt_stat  (mgmt_stat)
    );

    function automatic logic [31:0] exp_reset(int i);
        case (i)
            0: return 32'h0000_A800;  3: return 32'h12;  4: return 32'h0C;
            5: return 32'h12;  6: return 32'h0040_0600;  7: return 32'h000F_003F;
            8: return 32'h40;  10: return 32'h64;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_mask(int i);
        case (i)
            0: return 32'h1FFFF;  2, 3, 4, 5: return 32'h7F;
            6, 16, 18, 19: return 32'hFFFF_FFFF;  7: return 32'h000F_003F;
            8: return 32'hFF;  9: return 32'h7;  10: return 32'h3FF;
            12: return 32'h1F1F;  13, 17: return 32'hFFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] pat(int k);
        return 32'hC3A5_0000 ^ (32'(k) * 32'h0001_0101);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: one access; an irq pulse may ride on the accept edge.
    task automatic access(bit we, int word, logic [3:0] sel, logic [31:0] d,
                          int gap, logic [6:0] irq);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        #1;
        bus_we = we; bus_adr = 9'(word); bus_sel = sel; bus_wdat = d;
        bus_stb = 1'b1; irq_set = irq;
        @(negedge clk);
        check("R1 ack one cycle after accept", {31'h0, bus_ack}, 32'h1);
        #1;
        bus_stb = 1'b0; irq_set = '0;
    endtask

    task automatic wr(int word, logic [3:0] sel, logic [31:0] d, int gap = 0);
        access(1'b1, word, sel, d, gap, 7'h0);
    endtask

    task automatic rd(int word, logic [31:0] exp, string tag, int gap = 0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, word, 4'hF, 32'h0, gap, 7'h0);
    endtask

    task automatic hard_reset();
        @(negedge clk); #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Monitor: pops the scoreboard on every read acknowledge.
    always @(negedge clk) begin
        if (rst_n && bus_ack && !bus_we) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R1 unexpected read ack: got %h expected none", bus_rdat);
            end else begin
                check(tag_q.pop_front(), bus_rdat, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        repeat (4) @(negedge clk);
        check("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        check("R1 ack low after reset", {31'h0, bus_ack}, 32'h0);

        // R2: reset values
        for (int i = 0; i < 20; i++) rd(i, exp_reset(i), "R2 reset value");

        // R3 / R5 / R7: all-ones everywhere
        mgmt_rdata = 16'hA5C3;
        mgmt_stat  = 3'b101;
        for (int i = 0; i < 20; i++) wr(i, 4'hF, 32'hFFFF_FFFF, i % 3);
        for (int i = 0; i < 20; i++) begin
            if (i == 1)       rd(i, 32'h0, "R6 status untouched by ones-write");
            else if (i == 8)  rd(i, 32'h40, "R7 oversize write discarded");
            else if (i == 11) rd(i, 32'h0, "R5 command reads zero");
            else if (i == 14) rd(i, 32'h0000_A5C3, "R5 read data from port");
            else if (i == 15) rd(i, 32'h5, "R5 status from port");
            else              rd(i, exp_mask(i), "R3 writable mask");
        end

        // R2: hard reset wipes everything written
        mgmt_rdata = '0;
        mgmt_stat  = '0;
        hard_reset();
        for (int i = 0; i < 20; i++) rd(i, exp_reset(i), "R2 value after hard reset");

        // R4: byte selects
        wr(6, 4'b0101, 32'h1122_3344);
        rd(6, 32'h0022_0644, "R4 bytes 0 and 2 only");
        wr(17, 4'b0010, 32'hFFFF_FFFF);
        rd(17, 32'h0000_FF00, "R4 byte 1 only");

        // R7: descriptor count bounds
        wr(8, 4'hF, 32'h80);  rd(8, 32'h80, "R7 limit accepted");
        wr(8, 4'hF, 32'h7F);  rd(8, 32'h7F, "R7 below limit");
        wr(8, 4'hF, 32'h81);  rd(8, 32'h7F, "R7 above limit kept old");
        wr(8, 4'hF, 32'h0);   rd(8, 32'h0, "R7 zero accepted");
        wr(8, 4'b0010, 32'h0000_0100); rd(8, 32'h0, "R7 merged 0x100 rejected");

        // R6: set pulses and write-one-to-clear
        access(1'b1, 11, 4'hF, 32'h0, 0, 7'h15);
        rd(1, 32'h15, "R6 set pulses");
        wr(1, 4'b0001, 32'h05);
        rd(1, 32'h10, "R6 write-one-to-clear");
        wr(1, 4'b0000, 32'h7F);
        rd(1, 32'h10, "R6 clear needs byte select");
        access(1'b1, 1, 4'b0001, 32'h12, 0, 7'h02);
        rd(1, 32'h02, "R6 set wins over same-cycle clear");

        // R8: unmapped hole
        wr(20, 4'hF, 32'hFFFF_FFFF);
        wr(255, 4'hF, 32'hFFFF_FFFF);
        wr(128, 4'hF, 32'hFFFF_FFFF);
        rd(20, 32'h0, "R8 hole at 0x50");
        rd(255, 32'h0, "R8 hole at 0x3FC");
        rd(128, 32'h0, "R8 hole at 0x200");
        rd(19, 32'h0, "R8 hash high untouched by hole write");

        // R9: descriptor store survives hard reset
        for (int k = 0; k < 256; k++) wr(256 + k, 4'hF, pat(k), k % 2);
        hard_reset();
        for (int k = 0; k < 256; k++) rd(256 + k, pat(k), "R9 store kept across reset");
        wr(259, 4'b1000, 32'hEE00_0000);
        rd(259, (pat(3) & 32'h00FF_FFFF) | 32'hEE00_0000, "R4 store byte 3 only");

        // R10: varied idle gaps
        for (int g = 0; g < 5; g++) begin
            wr(3, 4'hF, 32'h50 + 32'(g), g);
            rd(3, 32'h50 + 32'(g), "R10 gap read-back", 4 - g);
        end

        finish_run();
    end

endmodule